// File: doc/BRIEF.md
# Processor Exception Entry Sequencer

This block sits beside a processor's fetch and execute logic and decides, whenever an instruction boundary is signalled, which of seven pending exception conditions is taken. For the chosen exception it computes, in one registered step, the status word the processor enters with, the value to keep as the saved status, the return link value and the vector address to fetch from next. It also gives a one-cycle taken strobe that tells the surrounding logic to load these values.

Requests are level inputs. The block stores no pending state of its own. A condition that loses arbitration stays pending as long as its source keeps it asserted, and it competes again at a later boundary.

The address input means the faulting instruction for aborts, undefined instructions and software interrupts. For the two interrupt kinds it means the next instruction to execute. Instructions are four bytes long.

Top module: `exc_entry_seq`

## Requirements
- R1: When several requests are eligible in the same sampled cycle, exactly one is taken, chosen in this fixed order from strongest to weakest: reset, data abort, fast interrupt, normal interrupt, prefetch abort, undefined instruction, software interrupt.
- R2: The new status mode field, bits [4:0], is 10011 for reset and software interrupt, 11011 for undefined instruction, 10111 for both aborts, 10010 for normal interrupt and 10001 for fast interrupt.
- R3: In the new status, bit 5 is cleared and bit 7 is set for every exception. Bit 6 is set for reset and fast interrupt and copied from the old status otherwise. Bits above 7 are copied from the old status.
- R4: The vector address is a base plus an offset. The base is 0xFFFF0000 when the high-vector input is 1 and 0 otherwise. The offset is 0x00 for reset, 0x04 for undefined, 0x08 for software interrupt, 0x0C for prefetch abort, 0x10 for data abort, 0x18 for normal interrupt and 0x1C for fast interrupt.
- R5: The link value is the address input + 8 for data abort. For every other non-reset exception it is the address input + 4.
- R6: For every non-reset exception, the saved-status output equals the status input sampled in the taking cycle.
- R7: A fast interrupt request is ignored while old status bit 6 is 1, and a normal interrupt request is ignored while bit 7 is 1. A masked request does not block weaker eligible requests.
- R8: Requests other than reset are considered only in cycles where the boundary input is 1. A reset request is taken in any cycle.
- R9: The taken strobe is 1 in the cycle after a sampled cycle with an eligible request and 0 otherwise. All other outputs hold their last values while no exception is taken.
- R10: During synchronous active-low reset, the taken strobe and all data outputs are driven to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boundary_i | input | 1 | Instruction boundary: non-reset requests are sampled |
| req_reset_i | input | 1 | Reset exception request |
| req_dabt_i | input | 1 | Data abort request |
| req_fiq_i | input | 1 | Fast interrupt request |
| req_irq_i | input | 1 | Normal interrupt request |
| req_pabt_i | input | 1 | Prefetch abort request |
| req_undef_i | input | 1 | Undefined instruction request |
| req_swi_i | input | 1 | Software interrupt request |
| status_i | input | 32 | Current status word |
| pc_i | input | 32 | Faulting or next instruction address |
| high_vec_i | input | 1 | Select the high vector base |
| taken_o | output | 1 | One-cycle strobe: exception entered |
| status_o | output | 32 | Status word to enter with |
| saved_o | output | 32 | Value for the saved status |
| link_o | output | 32 | Return link value |
| vector_o | output | 32 | New program counter |

## Verification
Every result is due exactly one clock after the edge that samples the requests, because the winner and all entry values pass through a single register stage. The bench changes inputs on the falling edge and compares all five outputs on the next falling edge, after that one rising edge. In cycles with nothing to take, it compares the data outputs against the values it predicted at the last take, so the hold behaviour is checked in the same slot.

// File: rtl/exc_entry_pkg.sv
// Package: shared exception kind encoding and per-kind constants.
// Assumes seven sources; kind index order is the priority order.
package exc_entry_pkg;

    localparam int NUM_SRC = 7;

    typedef enum logic [2:0] {
        EXK_NONE  = 3'd0,
        EXK_RESET = 3'd1,
        EXK_DABT  = 3'd2,
        EXK_FIQ   = 3'd3,
        EXK_IRQ   = 3'd4,
        EXK_PABT  = 3'd5,
        EXK_UNDEF = 3'd6,
        EXK_SWI   = 3'd7
    } exc_kind_e;

    // Mode field value entered for a given kind.
    function automatic logic [4:0] mode_of(exc_kind_e k);
        case (k)
            EXK_RESET, EXK_SWI: mode_of = 5'b10011;
            EXK_UNDEF:          mode_of = 5'b11011;
            EXK_DABT, EXK_PABT: mode_of = 5'b10111;
            EXK_IRQ:            mode_of = 5'b10010;
            EXK_FIQ:            mode_of = 5'b10001;
            default:            mode_of = 5'b00000;
        endcase
    endfunction

    // Vector offset in bytes from the selected base.
    function automatic logic [7:0] offset_of(exc_kind_e k);
        case (k)
            EXK_RESET: offset_of = 8'h00;
            EXK_UNDEF: offset_of = 8'h04;
            EXK_SWI:   offset_of = 8'h08;
            EXK_PABT:  offset_of = 8'h0C;
            EXK_DABT:  offset_of = 8'h10;
            EXK_IRQ:   offset_of = 8'h18;
            EXK_FIQ:   offset_of = 8'h1C;
            default:   offset_of = 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/exc_req_mask.sv
// Module: exc_req_mask
// Builds the eligible-request vector, index 0 strongest. Applies the
// interrupt mask bits from the old status and the boundary gate.
// Assumes status bit 6 masks the fast and bit 7 the normal interrupt.
module exc_req_mask
    import exc_entry_pkg::*;
#(
    parameter int STAT_W = 32
) (
    input  logic                boundary_i,
    input  logic                req_reset_i,
    input  logic                req_dabt_i,
    input  logic                req_fiq_i,
    input  logic                req_irq_i,
    input  logic                req_pabt_i,
    input  logic                req_undef_i,
    input  logic                req_swi_i,
    input  logic [STAT_W-1:0]   status_i,
    output logic [NUM_SRC-1:0]  elig_o
);

    localparam int F_BIT = 6;
    localparam int I_BIT = 7;

    // Gate requests by boundary and interrupt masks; reset is never gated.
    always_comb begin
        elig_o[0] = req_reset_i;
        elig_o[1] = boundary_i & req_dabt_i;
        elig_o[2] = boundary_i & req_fiq_i & ~status_i[F_BIT];
        elig_o[3] = boundary_i & req_irq_i & ~status_i[I_BIT];
        elig_o[4] = boundary_i & req_pabt_i;
        elig_o[5] = boundary_i & req_undef_i;
        elig_o[6] = boundary_i & req_swi_i;
    end

endmodule

// File: rtl/exc_prio_pick.sv
// Module: exc_prio_pick
// Fixed-priority pick: the lowest set index of the eligible vector wins
// and is returned as an exception kind (index + 1), or NONE.
module exc_prio_pick
    import exc_entry_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic [N-1:0] elig_i,
    output exc_kind_e    kind_o
);

    logic [N-1:0] blocked;
    logic [N-1:0] grant;

    // Prefix chain: a source is blocked if any stronger one is eligible.
    assign blocked[0] = 1'b0;
    assign grant[0]   = elig_i[0];
    generate
        for (genvar g = 1; g < N; g++) begin : g_chain
            assign blocked[g] = blocked[g-1] | elig_i[g-1];
            assign grant[g]   = elig_i[g] & ~blocked[g];
        end
    endgenerate

    // Encode the single grant into a kind.
    always_comb begin
        kind_o = EXK_NONE;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) kind_o = exc_kind_e'(3'(i + 1));
        end
    end

endmodule

// File: rtl/exc_state_calc.sv
// Module: exc_state_calc
// Computes entry status, saved status, link and vector for one kind.
// Assumes fixed-length instructions of INSN_BYTES bytes.
module exc_state_calc
    import exc_entry_pkg::*;
#(
    parameter int              STAT_W     = 32,
    parameter int              ADDR_W     = 32,
    parameter int              INSN_BYTES = 4,
    parameter logic [ADDR_W-1:0] HIGH_BASE = 32'hFFFF0000
) (
    input  exc_kind_e           kind_i,
    input  logic [STAT_W-1:0]   status_i,
    input  logic [ADDR_W-1:0]   pc_i,
    input  logic                high_vec_i,
    output logic [STAT_W-1:0]   status_o,
    output logic [STAT_W-1:0]   saved_o,
    output logic [ADDR_W-1:0]   link_o,
    output logic [ADDR_W-1:0]   vector_o
);

    localparam logic [ADDR_W-1:0] STEP1 = ADDR_W'(INSN_BYTES);
    localparam logic [ADDR_W-1:0] STEP2 = ADDR_W'(2 * INSN_BYTES);

    // New status: mode, state bit cleared, masks set per kind.
    always_comb begin
        status_o      = status_i;
        status_o[4:0] = mode_of(kind_i);
        status_o[5]   = 1'b0;
        status_o[7]   = 1'b1;
        if (kind_i == EXK_RESET || kind_i == EXK_FIQ) status_o[6] = 1'b1;
    end

    // Saved status is always the old word (don't-care on reset).
    assign saved_o = status_i;

    // Link: data abort returns two instructions on, all others one.
    assign link_o = pc_i + ((kind_i == EXK_DABT) ? STEP2 : STEP1);

    // Vector: base selected by configuration, plus per-kind offset.
    assign vector_o = (high_vec_i ? HIGH_BASE : '0) | ADDR_W'(offset_of(kind_i));

endmodule

// File: rtl/exc_entry_seq.sv
// Module: exc_entry_seq (top)
// Samples exception requests, picks the winner and registers the entry
// state with a one-cycle taken strobe. Outputs hold between takes.
// Assumes requests are level signals held by their sources.
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter int                STAT_W     = 32,
    parameter int                ADDR_W     = 32,
    parameter int                INSN_BYTES = 4,
    parameter logic [ADDR_W-1:0] HIGH_BASE  = 32'hFFFF0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               boundary_i,
    input  logic               req_reset_i,
    input  logic               req_dabt_i,
    input  logic               req_fiq_i,
    input  logic               req_irq_i,
    input  logic               req_pabt_i,
    input  logic               req_undef_i,
    input  logic               req_swi_i,
    input  logic [STAT_W-1:0]  status_i,
    input  logic [ADDR_W-1:0]  pc_i,
    input  logic               high_vec_i,
    output logic               taken_o,
    output logic [STAT_W-1:0]  status_o,
    output logic [STAT_W-1:0]  saved_o,
    output logic [ADDR_W-1:0]  link_o,
    output logic [ADDR_W-1:0]  vector_o
);

    logic [NUM_SRC-1:0] elig;
    exc_kind_e          kind;
    logic [STAT_W-1:0]  nx_status;
    logic [STAT_W-1:0]  nx_saved;
    logic [ADDR_W-1:0]  nx_link;
    logic [ADDR_W-1:0]  nx_vector;

    exc_req_mask #(.STAT_W(STAT_W)) u_mask (
        .boundary_i  (boundary_i),
        .req_reset_i (req_reset_i),
        .req_dabt_i  (req_dabt_i),
        .req_fiq_i   (req_fiq_i),
        .req_irq_i   (req_irq_i),
        .req_pabt_i  (req_pabt_i),
        .req_undef_i (req_undef_i),
        .req_swi_i   (req_swi_i),
        .status_i    (status_i),
        .elig_o      (elig)
    );

    exc_prio_pick #(.N(NUM_SRC)) u_pick (
        .elig_i (elig),
        .kind_o (kind)
    );

    exc_state_calc #(
        .STAT_W     (STAT_W),
        .ADDR_W     (ADDR_W),
        .INSN_BYTES (INSN_BYTES),
        .HIGH_BASE  (HIGH_BASE)
    ) u_calc (
        .kind_i     (kind),
        .status_i   (status_i),
        .pc_i       (pc_i),
        .high_vec_i (high_vec_i),
        .status_o   (nx_status),
        .saved_o    (nx_saved),
        .link_o     (nx_link),
        .vector_o   (nx_vector)
    );

    // Output register: load on a take, otherwise hold; strobe one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken_o  <= 1'b0;
            status_o <= '0;
            saved_o  <= '0;
            link_o   <= '0;
            vector_o <= '0;
        end else begin
            taken_o <= (kind != EXK_NONE);
            if (kind != EXK_NONE) begin
                status_o <= nx_status;
                saved_o  <= nx_saved;
                link_o   <= nx_link;
                vector_o <= nx_vector;
            end
        end
    end

endmodule

// File: rtl/exc_entry_chk.sv
// Module: exc_entry_chk
// Port-level properties of the exception entry sequencer, bound to top.
module exc_entry_chk #(
    parameter int                STAT_W    = 32,
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] HIGH_BASE = 32'hFFFF0000
) (
    input logic               clk,
    input logic               rst_n,
    input logic               boundary_i,
    input logic               req_reset_i,
    input logic               req_dabt_i,
    input logic               req_fiq_i,
    input logic               req_irq_i,
    input logic [STAT_W-1:0]  status_i,
    input logic               high_vec_i,
    input logic               taken_o,
    input logic [STAT_W-1:0]  status_o,
    input logic [STAT_W-1:0]  saved_o,
    input logic [ADDR_W-1:0]  vector_o
);

    // R1: reset wins over everything
    p_reset_wins_r1: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o && $past(req_reset_i) |-> status_o[4:0] == 5'b10011 && vector_o[7:0] == 8'h00);

    // R1: data abort wins when reset absent
    p_dabt_wins_r1: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o && $past(req_dabt_i && boundary_i && !req_reset_i) |-> vector_o[7:0] == 8'h10);

    // R3: state bit cleared, normal mask set
    p_entry_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |-> status_o[7] && !status_o[5]);

    // R4: base follows the configuration input
    p_base_r4: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |-> vector_o[ADDR_W-1:8] == ($past(high_vec_i) ? HIGH_BASE[ADDR_W-1:8] : '0));

    // R6: saved status is the old word
    p_saved_r6: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o && !$past(req_reset_i) |-> saved_o == $past(status_i));

    // R7: fast interrupt never entered while masked
    p_fmask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o && status_o[4:0] == 5'b10001 |-> $past(req_fiq_i) && !$past(status_i[6]));

    // R7: normal interrupt never entered while masked
    p_imask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o && status_o[4:0] == 5'b10010 |-> $past(req_irq_i) && !$past(status_i[7]));

    // R8: only boundary cycles or reset can cause a take
    p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |-> $past(boundary_i || req_reset_i));

    // R9: outputs hold when nothing taken
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !taken_o |-> $stable(vector_o) && $stable(status_o) && $stable(saved_o));

endmodule

bind exc_entry_seq exc_entry_chk #(
    .STAT_W    (STAT_W),
    .ADDR_W    (ADDR_W),
    .HIGH_BASE (HIGH_BASE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .boundary_i  (boundary_i),
    .req_reset_i (req_reset_i),
    .req_dabt_i  (req_dabt_i),
    .req_fiq_i   (req_fiq_i),
    .req_irq_i   (req_irq_i),
    .status_i    (status_i),
    .high_vec_i  (high_vec_i),
    .taken_o     (taken_o),
    .status_o    (status_o),
    .saved_o     (saved_o),
    .vector_o    (vector_o)
);

// File: tb/exc_entry_seq_tb.sv
// Bench: directed pair/mask cases plus seeded random stimulus against a
// behavioural model of the entry rules.
module exc_entry_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boundary_i = 1'b0;
    logic [6:0]  reqs = '0;   // bit0 reset .. bit6 software interrupt
    logic [31:0] status_i = '0;
    logic [31:0] pc_i = '0;
    logic        high_vec_i = 1'b0;
    logic        taken_o;
    logic [31:0] status_o, saved_o, link_o, vector_o;

    int n_checks = 0;
    int n_errors = 0;

    logic        e_taken;
    logic [31:0] e_status = '0, e_saved = '0, e_link = '0, e_vector = '0;
    logic        e_reset_kind;

    always #4 clk = ~clk;

    exc_entry_seq u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .boundary_i  (boundary_i),
        .req_reset_i (reqs[0]),
        .req_dabt_i  (reqs[1]),
        .req_fiq_i   (reqs[2]),
        .req_irq_i   (reqs[3]),
        .req_pabt_i  (reqs[4]),
        .req_undef_i (reqs[5]),
        .req_swi_i   (reqs[6]),
        .status_i    (status_i),
        .pc_i        (pc_i),
        .high_vec_i  (high_vec_i),
        .taken_o     (taken_o),
        .status_o    (status_o),
        .saved_o     (saved_o),
        .link_o      (link_o),
        .vector_o    (vector_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Model of R1..R8 for the current inputs; updates expected outputs.
    task automatic model();
        int win = -1;
        logic [6:0] el;
        el[0] = reqs[0];
        el[1] = boundary_i && reqs[1];
        el[2] = boundary_i && reqs[2] && !status_i[6];
        el[3] = boundary_i && reqs[3] && !status_i[7];
        el[4] = boundary_i && reqs[4];
        el[5] = boundary_i && reqs[5];
        el[6] = boundary_i && reqs[6];
        for (int i = 6; i >= 0; i--) if (el[i]) win = i;
        e_taken = (win >= 0);
        e_reset_kind = (win == 0);
        if (win >= 0) begin
            logic [4:0] m;
            logic [7:0] off;
            case (win)
                0: begin m = 5'b10011; off = 8'h00; end
                1: begin m = 5'b10111; off = 8'h10; end
                2: begin m = 5'b10001; off = 8'h1C; end
                3: begin m = 5'b10010; off = 8'h18; end
                4: begin m = 5'b10111; off = 8'h0C; end
                5: begin m = 5'b11011; off = 8'h04; end
                default: begin m = 5'b10011; off = 8'h08; end
            endcase
            e_status = {status_i[31:8], 1'b1, (win == 0 || win == 2) ? 1'b1 : status_i[6], 1'b0, m};
            e_saved  = status_i;
            e_link   = pc_i + ((win == 1) ? 32'd8 : 32'd4);
            e_vector = (high_vec_i ? 32'hFFFF0000 : 32'h0) | {24'h0, off};
        end
    endtask

    // One step: inputs already driven at a falling edge; compare one clock later.
    task automatic step(input string tag);
        model();
        @(posedge clk);
        @(negedge clk);
        check({tag, " R9 taken"}, {31'b0, taken_o}, {31'b0, e_taken});
        check({tag, " R2 R3 status"}, status_o, e_status);
        check({tag, " R4 vector"}, vector_o, e_vector);
        if (!e_reset_kind || !e_taken) begin
            check({tag, " R5 link"}, link_o, e_link);
            check({tag, " R6 saved"}, saved_o, e_saved);
        end
    endtask

    initial begin
        int unsigned seed = 32'd12345;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 taken", {31'b0, taken_o}, 32'd0);
        check("R10 vector", vector_o, 32'd0);
        check("R10 status", status_o, 32'd0);
        rst_n = 1'b1;

        // R1 R4: every pair of simultaneous requests, both bases
        for (int hv = 0; hv < 2; hv++)
            for (int a = 0; a < 7; a++)
                for (int b = a + 1; b < 7; b++) begin
                    boundary_i = 1'b1; high_vec_i = hv[0];
                    reqs = 7'(1 << a) | 7'(1 << b);
                    status_i = 32'hA5A5_5A10; pc_i = 32'h0000_1000 + 32'(a * 16 + b * 4);
                    step("R1 pair");
                    reqs = '0; boundary_i = 1'b0;
                    step("R9 idle");
                end

        // R7: masked fast interrupt with swi pending; swi must win
        boundary_i = 1'b1; reqs = 7'b1000100; status_i = 32'h0000_0050; pc_i = 32'h200;
        step("R7 fmask");
        // R7: masked normal interrupt with undef pending
        reqs = 7'b0101000; status_i = 32'h0000_0090; step("R7 imask");
        // R7: masked fast alone, nothing taken
        reqs = 7'b0000100; status_i = 32'h0000_00D0; step("R7 fonly");
        // R3: fast clear mask, normal set - fast taken, bit6 set
        reqs = 7'b0001100; status_i = 32'hF000_0080; step("R3 fiq");
        // R8: no boundary, irq ignored; reset still taken
        boundary_i = 1'b0; reqs = 7'b0001000; status_i = 32'h0; step("R8 noboundary");
        reqs = 7'b0000001; step("R8 reset");

        // Random mix
        for (int k = 0; k < 3000; k++) begin
            boundary_i = 1'($urandom);
            reqs = 7'($urandom) & ((($urandom % 4) == 0) ? 7'h7F : 7'h7E);
            status_i = $urandom;
            pc_i = $urandom & 32'hFFFF_FFFC;
            high_vec_i = 1'($urandom);
            step("R1 R5 random");
        end
        reqs = '0; boundary_i = 1'b0;
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    // Watchdog
    initial begin
        #1_000_000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule